// File: doc/BRIEF.md
# Walsh Component Summation Sequencer

This block is the shared timing engine for a bank of voice channels that each build a waveform sample as a weighted sum of Walsh components. Every voice holds a signed 8-bit weight for each of 32 components in a small store. The sequencer steps all voices together through the component indices. At each step every voice adds its weight for the current component, either unchanged or negated according to that voice's Walsh bit. After the last component it freezes every voice's total and restarts the running sums from zero.

The host bus clock has two phases, and the sequencer follows phase 2. The sequencer advances one component on each rising edge of phase 2, sampled in the system clock domain. While phase 2 is high the weight stores belong to the host: their address comes from the host address bits and their access mode is set for the host. While phase 2 is low the sequencer owns the stores and presents its own component index. The upper bits of the step counter select one voice at a time during the following pass. That voice's frozen total, with its least significant bit dropped, is driven onto a shared output bus.

Top module: `walsh_sum_sequencer`

## Requirements
- R1: The step counter advances exactly once per rising edge of `ph2_i`. Holding `ph2_i` high or low for any number of clock cycles adds no further step.
- R2: While `ph2_i` is high, `store_addr_o` equals `host_addr_i` and `store_owner_o` is 1 (host owns the stores).
- R3: While `ph2_i` is low, `store_addr_o` equals the low 5 bits of the step counter (the component index, 0 to 31) and `store_owner_o` is 0.
- R4: At each step every channel adds the two's complement weight on its slice of `mag_i` (channel k uses bits 8k+7..8k) to its running sum. The weight is added unchanged when that channel's `wbit_i` bit is 1 and negated when it is 0. Weights lie in -127..127.
- R5: On the step that consumes component 31, every channel stores its full 32-term total and clears its running sum on the same clock edge. `done_o` then goes high and stays high until the next step, exactly one step long.
- R6: After a step, the upper 4 counter bits form a channel code k. When k is below NCH, `bus_en_o` has only bit k set.
- R7: When the channel code is NCH or above (10 to 15 by default), `bus_en_o` is all zero and `out_o` is zero.
- R8: `out_o` equals the stored total of the enabled channel shifted right arithmetically by one bit (13-bit total to 12-bit output).
- R9: An active-high synchronous reset clears the counter, running sums and stored totals, deasserts `done_o`, and leaves every bus enable off until the first step.
- R10: A reset in the middle of a pass discards the partial sums, so the next stored totals contain only the steps taken after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ph2_i | input | 1 | Host bus phase-2 level, synchronous to clk |
| host_addr_i | input | 5 | Host address bits for the weight stores |
| mag_i | input | 80 | Per-channel signed weight for the current component, 8 bits per channel |
| wbit_i | input | 10 | Per-channel Walsh bit for the current component (1 pass, 0 negate) |
| store_addr_o | output | 5 | Address presented to all weight stores |
| store_owner_o | output | 1 | 1 when the host owns the stores, 0 when the sequencer does |
| done_o | output | 1 | Count-complete flag, high for one step after each 32-step pass |
| bus_en_o | output | 10 | One-hot output-bus enable per channel |
| out_o | output | 12 | Shared output bus carrying the selected channel's total |

## Verification
The bench builds the block with its defaults: ten channels, a 4-bit channel code and 32 components. Each group of 16 passes therefore walks through every channel code, including the six idle codes 10 to 15, and the bench runs several such groups. Weight patterns include full-scale ±127 in both Walsh polarities, which drives the totals to ±4064 and the output to ±2032. A reset in mid-pass and stretched high and low phases check that partial sums are dropped and that steps follow only the rising edges of phase 2.

// File: rtl/wss_pkg.sv
package wss_pkg;

    localparam int unsigned DEF_NCH      = 10;
    localparam int unsigned DEF_CMP_BITS = 5;
    localparam int unsigned DEF_SEL_BITS = 4;
    localparam int unsigned DEF_MAG_W    = 8;

    // Who drives the weight-store address and access mode
    typedef enum logic {
        OWN_HW   = 1'b0,
        OWN_HOST = 1'b1
    } store_owner_e;

    // Per-clock sequencing event shared by all channels
    typedef struct packed {
        logic step;   // rising edge of phase 2 seen this cycle
        logic wrap;   // this step consumes the last component
    } tick_t;

    function automatic int unsigned acc_width(int unsigned mag_w, int unsigned cmp_bits);
        return mag_w + cmp_bits;
    endfunction

endpackage

// File: rtl/wss_step_counter.sv
module wss_step_counter
    import wss_pkg::*;
#(
    parameter int unsigned CMP_BITS = DEF_CMP_BITS,
    parameter int unsigned SEL_BITS = DEF_SEL_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ph2_i,
    output tick_t               tick_o,
    output logic [CMP_BITS-1:0] comp_o,
    output logic [SEL_BITS-1:0] sel_nxt_o,
    output logic                done_o
);
    localparam int unsigned CW = CMP_BITS + SEL_BITS;
    localparam logic [CMP_BITS-1:0] LAST_COMP = '1;

    logic          ph2_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;
    logic          done_q;

    always_comb begin
        cnt_nxt     = cnt_q + CW'(1);
        tick_o.step = ph2_i & ~ph2_q;
        tick_o.wrap = tick_o.step & (cnt_q[CMP_BITS-1:0] == LAST_COMP);
        comp_o      = cnt_q[CMP_BITS-1:0];
        sel_nxt_o   = cnt_nxt[CW-1:CMP_BITS];
        done_o      = done_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph2_q  <= 1'b1;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            ph2_q <= ph2_i;
            if (tick_o.step) begin
                cnt_q  <= cnt_nxt;
                done_q <= tick_o.wrap;
            end
        end
    end

endmodule

// File: rtl/wss_addr_switch.sv
module wss_addr_switch
    import wss_pkg::*;
#(
    parameter int unsigned CMP_BITS = DEF_CMP_BITS
) (
    input  logic                ph2_i,
    input  logic [CMP_BITS-1:0] host_addr_i,
    input  logic [CMP_BITS-1:0] comp_i,
    output logic [CMP_BITS-1:0] store_addr_o,
    output store_owner_e        owner_o
);
    always_comb begin
        if (ph2_i) begin
            owner_o      = OWN_HOST;
            store_addr_o = host_addr_i;
        end else begin
            owner_o      = OWN_HW;
            store_addr_o = comp_i;
        end
    end

endmodule

// File: rtl/wss_chan_accum.sv
module wss_chan_accum
    import wss_pkg::*;
#(
    parameter int unsigned MAG_W = DEF_MAG_W,
    parameter int unsigned ACC_W = acc_width(DEF_MAG_W, DEF_CMP_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  tick_t            tick_i,
    input  logic [MAG_W-1:0] mag_i,
    input  logic             wbit_i,
    output logic [ACC_W-1:0] total_o
);
    localparam int unsigned EXT_W = ACC_W - MAG_W;

    logic [ACC_W-1:0] ext;
    logic [ACC_W-1:0] term;
    logic [ACC_W-1:0] run_q;
    logic [ACC_W-1:0] run_nxt;
    logic [ACC_W-1:0] total_q;

    always_comb begin
        ext     = {{EXT_W{mag_i[MAG_W-1]}}, mag_i};
        term    = wbit_i ? ext : (~ext + ACC_W'(1));
        run_nxt = run_q + term;
        total_o = total_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            total_q <= '0;
        end else if (tick_i.step) begin
            if (tick_i.wrap) begin
                total_q <= run_nxt;
                run_q   <= '0;
            end else begin
                run_q <= run_nxt;
            end
        end
    end

endmodule

// File: rtl/wss_bus_select.sv
module wss_bus_select
    import wss_pkg::*;
#(
    parameter int unsigned NCH      = DEF_NCH,
    parameter int unsigned SEL_BITS = DEF_SEL_BITS,
    parameter int unsigned ACC_W    = acc_width(DEF_MAG_W, DEF_CMP_BITS),
    parameter int unsigned OUT_W    = ACC_W - 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  tick_t                     tick_i,
    input  logic [SEL_BITS-1:0]       sel_nxt_i,
    input  logic [NCH-1:0][ACC_W-1:0] totals_i,
    output logic [NCH-1:0]            bus_en_o,
    output logic [OUT_W-1:0]          out_o
);
    logic [NCH-1:0] dec;
    logic [NCH-1:0] en_q;

    for (genvar k = 0; k < NCH; k++) begin : g_dec
        assign dec[k] = (sel_nxt_i == SEL_BITS'(k));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (tick_i.step) begin
            en_q <= dec;
        end
    end

    always_comb begin
        bus_en_o = en_q;
        out_o    = '0;
        for (int k = 0; k < NCH; k++) begin
            if (en_q[k]) begin
                out_o = out_o | totals_i[k][ACC_W-1:ACC_W-OUT_W];
            end
        end
    end

endmodule

// File: rtl/walsh_sum_sequencer.sv
module walsh_sum_sequencer
    import wss_pkg::*;
#(
    parameter int unsigned NCH      = DEF_NCH,
    parameter int unsigned CMP_BITS = DEF_CMP_BITS,
    parameter int unsigned SEL_BITS = DEF_SEL_BITS,
    parameter int unsigned MAG_W    = DEF_MAG_W,
    localparam int unsigned ACC_W   = acc_width(MAG_W, CMP_BITS),
    localparam int unsigned OUT_W   = ACC_W - 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ph2_i,
    input  logic [CMP_BITS-1:0]    host_addr_i,
    input  logic [NCH*MAG_W-1:0]   mag_i,
    input  logic [NCH-1:0]         wbit_i,
    output logic [CMP_BITS-1:0]    store_addr_o,
    output logic                   store_owner_o,
    output logic                   done_o,
    output logic [NCH-1:0]         bus_en_o,
    output logic [OUT_W-1:0]       out_o
);
    tick_t                     tick;
    logic [CMP_BITS-1:0]       comp;
    logic [SEL_BITS-1:0]       sel_nxt;
    store_owner_e              owner;
    logic [NCH-1:0][ACC_W-1:0] totals;

    wss_step_counter #(
        .CMP_BITS (CMP_BITS),
        .SEL_BITS (SEL_BITS)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .ph2_i     (ph2_i),
        .tick_o    (tick),
        .comp_o    (comp),
        .sel_nxt_o (sel_nxt),
        .done_o    (done_o)
    );

    wss_addr_switch #(
        .CMP_BITS (CMP_BITS)
    ) u_sw (
        .ph2_i        (ph2_i),
        .host_addr_i  (host_addr_i),
        .comp_i       (comp),
        .store_addr_o (store_addr_o),
        .owner_o      (owner)
    );

    assign store_owner_o = (owner == OWN_HOST);

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        wss_chan_accum #(
            .MAG_W (MAG_W),
            .ACC_W (ACC_W)
        ) u_acc (
            .clk     (clk),
            .rst     (rst),
            .tick_i  (tick),
            .mag_i   (mag_i[k*MAG_W +: MAG_W]),
            .wbit_i  (wbit_i[k]),
            .total_o (totals[k])
        );
    end

    wss_bus_select #(
        .NCH      (NCH),
        .SEL_BITS (SEL_BITS),
        .ACC_W    (ACC_W),
        .OUT_W    (OUT_W)
    ) u_bus (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .sel_nxt_i (sel_nxt),
        .totals_i  (totals),
        .bus_en_o  (bus_en_o),
        .out_o     (out_o)
    );

endmodule

// File: rtl/wss_seq_chk.sv
module wss_seq_chk #(
    parameter int unsigned NCH      = 10,
    parameter int unsigned CMP_BITS = 5,
    parameter int unsigned OUT_W    = 12
) (
    input logic                clk,
    input logic                rst,
    input logic                ph2_i,
    input logic [CMP_BITS-1:0] store_addr_o,
    input logic                done_o,
    input logic [NCH-1:0]      bus_en_o,
    input logic [OUT_W-1:0]    out_o
);
    // R6
    bus_en_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bus_en_o));

    // R7
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_en_o == '0) |-> (out_o == '0));

    // R9
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (bus_en_o == '0) && !done_o);

    // R1
    low_phase_addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!ph2_i && $past(!ph2_i)) |-> $stable(store_addr_o));

    // R5
    done_at_comp_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !ph2_i) |-> (store_addr_o == '0));

    // R5
    done_one_step_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && $rose(ph2_i)) |=> !done_o);

endmodule

bind walsh_sum_sequencer wss_seq_chk #(
    .NCH      (NCH),
    .CMP_BITS (CMP_BITS),
    .OUT_W    (OUT_W)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .ph2_i        (ph2_i),
    .store_addr_o (store_addr_o),
    .done_o       (done_o),
    .bus_en_o     (bus_en_o),
    .out_o        (out_o)
);

// File: tb/walsh_sum_sequencer_tb_top.sv
module walsh_sum_sequencer_tb_top;
    localparam int NCH   = 10;
    localparam int CB    = 5;
    localparam int SB    = 4;
    localparam int MW    = 8;
    localparam int OW    = 12;
    localparam int NCOMP = 1 << CB;
    localparam int NCNT  = 1 << (CB + SB);

    typedef struct {
        int             addr;
        bit             done;
        logic [NCH-1:0] en;
        int             out;
    } exp_t;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                ph2 = 1'b0;
    logic [CB-1:0]       host_addr = '0;
    logic [NCH*MW-1:0]   mag = '0;
    logic [NCH-1:0]      wbit = '0;
    logic [CB-1:0]       store_addr;
    logic                store_owner;
    logic                done;
    logic [NCH-1:0]      bus_en;
    logic [OW-1:0]       out_bus;

    int   n_chk  = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;
    exp_t exp_q[$];
    event sample_ev;

    int   m_cnt;
    int   m_acc[NCH];
    int   m_lat[NCH];
    bit   m_done;
    bit   m_live;

    always #10 clk = ~clk;

    walsh_sum_sequencer dut_i (
        .clk           (clk),
        .rst           (rst),
        .ph2_i         (ph2),
        .host_addr_i   (host_addr),
        .mag_i         (mag),
        .wbit_i        (wbit),
        .store_addr_o  (store_addr),
        .store_owner_o (store_owner),
        .done_o        (done),
        .bus_en_o      (bus_en),
        .out_o         (out_bus)
    );

    task automatic check_int(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt  = 0;
        m_done = 0;
        m_live = 0;
        for (int k = 0; k < NCH; k++) begin
            m_acc[k] = 0;
            m_lat[k] = 0;
        end
    endtask

    function automatic int weight(int rnd, int ch, int comp);
        if (rnd == 1) return (ch % 3 == 1) ? -127 : 127;
        return ((ch * 37 + comp * 11 + rnd * 5) % 255) - 127;
    endfunction

    function automatic bit wsign(int rnd, int ch, int comp);
        if (rnd == 1) return (ch % 4 != 3);
        return ($countones(comp & (ch + 1)) % 2) == 0;
    endfunction

    // Driver: one phase-2 cycle with optional stretched low and high phases
    task automatic do_step(input int rnd, input int xlow, input int xhigh);
        int comp;
        exp_t e;
        int sel;
        comp = m_cnt % NCOMP;
        ph2 = 1'b0;
        for (int k = 0; k < NCH; k++) begin
            int w;
            w = weight(rnd, k, comp);
            mag[k*MW +: MW] = MW'(w);
            wbit[k] = wsign(rnd, k, comp);
        end
        host_addr = CB'((m_cnt * 7 + 3) % NCOMP);
        repeat (1 + xlow) @(negedge clk);
        ph2 = 1'b1;
        @(posedge clk);
        // R4 R5: model of the step just taken
        for (int k = 0; k < NCH; k++) begin
            int t;
            t = wbit[k] ? weight(rnd, k, comp) : -weight(rnd, k, comp);
            if (comp == NCOMP - 1) begin
                m_lat[k] = m_acc[k] + t;
                m_acc[k] = 0;
            end else begin
                m_acc[k] = m_acc[k] + t;
            end
        end
        m_done = (comp == NCOMP - 1);
        m_cnt  = (m_cnt + 1) % NCNT;
        m_live = 1;
        repeat (1 + xhigh) begin
            @(negedge clk);
            // R2: host owns the stores during phase 2 high
            check_int("R2 host addr", int'(store_addr), int'(host_addr));
            check_int("R2 owner", int'(store_owner), 1);
        end
        ph2 = 1'b0;
        sel = m_cnt / NCOMP;
        e.addr = m_cnt % NCOMP;
        e.done = m_done;
        e.en   = (m_live && sel < NCH) ? (NCH'(1) << sel) : '0;
        e.out  = (m_live && sel < NCH) ? (m_lat[sel] >>> 1) : 0;
        exp_q.push_back(e);
        @(negedge clk);
        ->sample_ev;
    endtask

    // Monitor: compares the low-phase view against the queued expectation
    initial begin
        forever begin
            exp_t e;
            @(sample_ev);
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R3: no expectation queued, actual addr %0d expected none", store_addr);
            end else begin
                e = exp_q.pop_front();
                check_int("R3 R1 comp addr", int'(store_addr), e.addr);
                check_int("R3 owner", int'(store_owner), 0);
                check_int("R5 done", int'(done), int'(e.done));
                check_int("R6 R7 bus enable", int'(bus_en), int'(e.en));
                check_int("R8 R7 out bus", int'($signed(out_bus)), e.out);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check_int("R9 addr", int'(store_addr), 0);
        check_int("R9 done", int'(done), 0);
        check_int("R9 bus enable", int'(bus_en), 0);
        check_int("R9 out", int'(out_bus), 0);

        // R4 R6 R7 R8: mixed weights over all 16 channel codes
        for (int s = 0; s < NCNT; s++) do_step(0, 0, 0);
        // R4 R8: full-scale weights, both polarities
        for (int s = 0; s < NCNT; s++) do_step(1, 0, 0);

        // R10: reset in the middle of a pass
        for (int s = 0; s < 45; s++) do_step(2, 0, 0);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        check_int("R10 enable after reset", int'(bus_en), 0);
        check_int("R10 done after reset", int'(done), 0);

        // R1: stretched phases mixed with normal ones
        for (int s = 0; s < NCNT; s++) begin
            do_step(3, (s % 5 == 0) ? 4 : 0, (s % 7 == 0) ? 5 : 0);
        end

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule